// File: doc/BRIEF.md
# On-Demand Clock Request Network

This block produces the enable signals for a clock tree with three levels. Peripherals raise clock requests. Each peripheral is mapped to one generic clock generator, and each generator is mapped to one clock source. The block carries each request up through these two maps. It decides which generators and which sources must run, which peripherals receive a bus clock, and whether the main clock runs. The decision depends on the power mode, on a per-source on-demand qualifier, and on run-in-standby qualifiers for generators and sources. The outputs are enables only. The clock muxes and dividers sit outside the block.

A small mode state machine tracks the power mode: ST_ACTIVE, ST_IDLE and ST_STANDBY. The mode code changes it through six named transitions:
- T_NAP: ACTIVE to IDLE.
- T_DEEP_SLEEP: ACTIVE to STANDBY.
- T_DEEPEN: IDLE to STANDBY.
- T_IDLE_WAKE: IDLE to ACTIVE.
- T_STBY_WAKE: STANDBY to ACTIVE.
- T_LIGHTEN: STANDBY to IDLE.

The reserved code triggers no transition. The block computes all enables combinationally from the next mode and the current inputs, and registers them once. Every output therefore reflects the inputs present at the previous clock edge.

Top module: `odcr_net`

## Requirements
- R1: While reset is low, every enable output is low and the tracked mode is ACTIVE.
- R2: Mode code 0 selects ACTIVE, 1 selects IDLE and 2 selects STANDBY. Code 3 is reserved and leaves the tracked mode unchanged.
- R3: In ACTIVE and IDLE, generator 0 is always enabled.
- R4: In ACTIVE and IDLE, a generator other than 0 is enabled exactly when at least one requesting peripheral selects it. Peripheral p selects its generator through bits [2p+1:2p] of the peripheral map.
- R5: In STANDBY, any generator, including generator 0, is enabled only when its run-in-standby bit is set and at least one requesting peripheral selects it.
- R6: A source whose on-demand bit is set is enabled exactly when at least one enabled generator selects it. Generator g selects its source through bits [2g+1:2g] of the source map, and the value 3 selects no source.
- R7: Outside STANDBY, a source whose on-demand bit is clear is enabled whatever the requests.
- R8: In STANDBY, a source whose run-in-standby bit is clear is disabled. A source whose run-in-standby bit is set follows R6 and R7.
- R9: In ACTIVE, every peripheral bus clock is enabled. In IDLE and STANDBY, a peripheral's bus clock is enabled exactly when that peripheral requests.
- R10: The main clock enable is high in ACTIVE and IDLE. In STANDBY it is high only while some peripheral requests.
- R11: Every enable output changes only at a clock edge, one cycle after the inputs that cause it.
- R12: An on-demand source that is stopped restarts one cycle after a peripheral starts requesting from a generator that the source feeds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_mode | input | 2 | Power mode code (0 active, 1 idle, 2 standby, 3 reserved) |
| periph_req | input | 8 | Clock request, one bit per peripheral |
| periph_gen_sel | input | 16 | Generator index per peripheral, 2 bits each |
| gen_src_sel | input | 8 | Source index per generator, 2 bits each |
| gen_runstdby | input | 4 | Run-in-standby bit per generator |
| src_ondemand | input | 3 | On-demand bit per source |
| src_runstdby | input | 3 | Run-in-standby bit per source |
| gen_en | output | 4 | Registered generator enables |
| src_en | output | 3 | Registered source enables |
| bus_en | output | 8 | Registered bus clock enable per peripheral |
| main_clk_en | output | 1 | Registered main clock enable |

## Verification
The bench targets five corner cases:
- Generator 0 in standby. A design that exempts it from the run-in-standby rule would keep it running in STANDBY.
- The unused source index 3. A design that decodes it loosely would wake a source that no generator selects.
- The reserved mode code. A design that decodes it as ACTIVE would re-enable every bus clock in the middle of STANDBY.
- A source restart behind a disabled generator. A source that follows raw requests instead of enabled generators would run in STANDBY behind a gated generator.
- The one-cycle registration. The bench compares outputs just before each edge as well as after it, so a design with no register or with two registers fails at once.

// File: rtl/odcr_pkg.sv
package odcr_pkg;

    // Mode code on the pwr_mode pins
    localparam logic [1:0] PM_CODE_ACTIVE  = 2'd0;
    localparam logic [1:0] PM_CODE_IDLE    = 2'd1;
    localparam logic [1:0] PM_CODE_STANDBY = 2'd2;
    localparam logic [1:0] PM_CODE_RSVD    = 2'd3;

    // Tracked power mode state
    typedef enum logic [1:0] {
        ST_ACTIVE  = 2'd0,
        ST_IDLE    = 2'd1,
        ST_STANDBY = 2'd2
    } mode_st_e;

endpackage

// File: rtl/odcr_mode_fsm.sv
module odcr_mode_fsm
    import odcr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] pm_code,
    output logic       nxt_active,
    output logic       nxt_stby
);

    mode_st_e mode_q;
    mode_st_e mode_n;

    // Next-state logic with named transitions
    always_comb begin
        mode_n = mode_q;
        unique case (mode_q)
            ST_ACTIVE: begin
                if (pm_code == PM_CODE_IDLE)         mode_n = ST_IDLE;     // T_NAP
                else if (pm_code == PM_CODE_STANDBY) mode_n = ST_STANDBY;  // T_DEEP_SLEEP
            end
            ST_IDLE: begin
                if (pm_code == PM_CODE_ACTIVE)       mode_n = ST_ACTIVE;   // T_IDLE_WAKE
                else if (pm_code == PM_CODE_STANDBY) mode_n = ST_STANDBY;  // T_DEEPEN
            end
            ST_STANDBY: begin
                if (pm_code == PM_CODE_ACTIVE)       mode_n = ST_ACTIVE;   // T_STBY_WAKE
                else if (pm_code == PM_CODE_IDLE)    mode_n = ST_IDLE;     // T_LIGHTEN
            end
            default: mode_n = ST_ACTIVE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= ST_ACTIVE;
        else        mode_q <= mode_n;
    end

    // Output decode of the mode taking effect at the coming edge
    always_comb begin
        nxt_active = 1'b0;
        nxt_stby   = 1'b0;
        unique case (mode_n)
            ST_ACTIVE:  nxt_active = 1'b1;
            ST_IDLE:    ;
            ST_STANDBY: nxt_stby = 1'b1;
            default:    nxt_active = 1'b1;
        endcase
    end

endmodule

// File: rtl/odcr_gen_stage.sv
module odcr_gen_stage #(
    parameter int N_PERIPH = 8,
    parameter int N_GEN    = 4,
    localparam int GW      = (N_GEN > 1) ? $clog2(N_GEN) : 1
) (
    input  logic [N_PERIPH-1:0]    periph_req,
    input  logic [N_PERIPH*GW-1:0] periph_gen_sel,
    input  logic [N_GEN-1:0]       gen_runstdby,
    input  logic                   in_stby,
    output logic [N_GEN-1:0]       gen_en_d
);

    logic [N_GEN-1:0] gen_demand;

    // Gather requests onto the generators they select
    always_comb begin
        gen_demand = '0;
        for (int p = 0; p < N_PERIPH; p++) begin
            for (int g = 0; g < N_GEN; g++) begin
                if (periph_req[p] && (periph_gen_sel[p*GW +: GW] == GW'(g)))
                    gen_demand[g] = 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen
        if (g == 0) begin : g_primary
            // Generator 0 stays on unless in standby
            assign gen_en_d[g] = in_stby ? (gen_runstdby[g] & gen_demand[g]) : 1'b1;
        end else begin : g_secondary
            assign gen_en_d[g] = in_stby ? (gen_runstdby[g] & gen_demand[g]) : gen_demand[g];
        end
    end

endmodule

// File: rtl/odcr_src_stage.sv
module odcr_src_stage #(
    parameter int N_GEN   = 4,
    parameter int N_SRC   = 3,
    localparam int SW     = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_GEN-1:0]    gen_en_d,
    input  logic [N_GEN*SW-1:0] gen_src_sel,
    input  logic [N_SRC-1:0]    src_ondemand,
    input  logic [N_SRC-1:0]    src_runstdby,
    input  logic                in_stby,
    output logic [N_SRC-1:0]    src_en_d
);

    logic [N_SRC-1:0] src_demand;

    // A source is wanted when an enabled generator selects it
    always_comb begin
        src_demand = '0;
        for (int g = 0; g < N_GEN; g++) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (gen_en_d[g] && (gen_src_sel[g*SW +: SW] == SW'(s)))
                    src_demand[s] = 1'b1;
            end
        end
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        logic awake_rule;
        assign awake_rule  = src_ondemand[s] ? src_demand[s] : 1'b1;
        assign src_en_d[s] = (in_stby && !src_runstdby[s]) ? 1'b0 : awake_rule;
    end

endmodule

// File: rtl/odcr_bus_gate.sv
module odcr_bus_gate #(
    parameter int N_PERIPH = 8
) (
    input  logic [N_PERIPH-1:0] periph_req,
    input  logic                in_active,
    input  logic                in_stby,
    output logic [N_PERIPH-1:0] bus_en_d,
    output logic                main_en_d
);

    always_comb begin
        if (in_active) bus_en_d = '1;
        else           bus_en_d = periph_req;
    end

    always_comb begin
        if (in_stby) main_en_d = |periph_req;
        else         main_en_d = 1'b1;
    end

endmodule

// File: rtl/odcr_net.sv
module odcr_net #(
    parameter int N_PERIPH = 8,
    parameter int N_GEN    = 4,
    parameter int N_SRC    = 3,
    localparam int GW      = (N_GEN > 1) ? $clog2(N_GEN) : 1,
    localparam int SW      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             pwr_mode,
    input  logic [N_PERIPH-1:0]    periph_req,
    input  logic [N_PERIPH*GW-1:0] periph_gen_sel,
    input  logic [N_GEN*SW-1:0]    gen_src_sel,
    input  logic [N_GEN-1:0]       gen_runstdby,
    input  logic [N_SRC-1:0]       src_ondemand,
    input  logic [N_SRC-1:0]       src_runstdby,
    output logic [N_GEN-1:0]       gen_en,
    output logic [N_SRC-1:0]       src_en,
    output logic [N_PERIPH-1:0]    bus_en,
    output logic                   main_clk_en
);

    logic                nxt_active;
    logic                nxt_stby;
    logic [N_GEN-1:0]    gen_en_d;
    logic [N_SRC-1:0]    src_en_d;
    logic [N_PERIPH-1:0] bus_en_d;
    logic                main_en_d;

    odcr_mode_fsm u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .pm_code    (pwr_mode),
        .nxt_active (nxt_active),
        .nxt_stby   (nxt_stby)
    );

    odcr_gen_stage #(.N_PERIPH(N_PERIPH), .N_GEN(N_GEN)) u_gen (
        .periph_req     (periph_req),
        .periph_gen_sel (periph_gen_sel),
        .gen_runstdby   (gen_runstdby),
        .in_stby        (nxt_stby),
        .gen_en_d       (gen_en_d)
    );

    odcr_src_stage #(.N_GEN(N_GEN), .N_SRC(N_SRC)) u_src (
        .gen_en_d     (gen_en_d),
        .gen_src_sel  (gen_src_sel),
        .src_ondemand (src_ondemand),
        .src_runstdby (src_runstdby),
        .in_stby      (nxt_stby),
        .src_en_d     (src_en_d)
    );

    odcr_bus_gate #(.N_PERIPH(N_PERIPH)) u_bus (
        .periph_req (periph_req),
        .in_active  (nxt_active),
        .in_stby    (nxt_stby),
        .bus_en_d   (bus_en_d),
        .main_en_d  (main_en_d)
    );

    // Single output register stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gen_en      <= '0;
            src_en      <= '0;
            bus_en      <= '0;
            main_clk_en <= 1'b0;
        end else begin
            gen_en      <= gen_en_d;
            src_en      <= src_en_d;
            bus_en      <= bus_en_d;
            main_clk_en <= main_en_d;
        end
    end

    AST_GEN0_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd0 || pwr_mode == 2'd1) |=> gen_en[0]); // R3

    AST_ACTIVE_BUS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd0) |=> (&bus_en && main_clk_en)); // R9

    AST_MAIN_STBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_mode == 2'd2 && periph_req == '0) |=> !main_clk_en); // R10

    for (genvar g = 0; g < N_GEN; g++) begin : g_gen_chk
        AST_GEN_STBY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_mode == 2'd2 && !gen_runstdby[g]) |=> !gen_en[g]); // R5
    end

    for (genvar s = 0; s < N_SRC; s++) begin : g_src_chk
        AST_SRC_STBY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_mode == 2'd2 && !src_runstdby[s]) |=> !src_en[s]); // R8
        AST_SRC_FREE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            ((pwr_mode == 2'd0 || pwr_mode == 2'd1) && !src_ondemand[s]) |=> src_en[s]); // R7
    end

    for (genvar p = 0; p < N_PERIPH; p++) begin : g_bus_chk
        AST_BUS_UNREQ_OFF: assert property (@(posedge clk) disable iff (!rst_n)
            ((pwr_mode == 2'd1 || pwr_mode == 2'd2) && !periph_req[p]) |=> !bus_en[p]); // R9
    end

endmodule

// File: tb/odcr_net_test.sv
module odcr_net_test;

    localparam int NP = 8;
    localparam int NG = 4;
    localparam int NS = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    pwr_mode = '0;
    logic [NP-1:0] periph_req = '0;
    logic [2*NP-1:0] periph_gen_sel = '0;
    logic [2*NG-1:0] gen_src_sel = '0;
    logic [NG-1:0] gen_runstdby = '0;
    logic [NS-1:0] src_ondemand = '0;
    logic [NS-1:0] src_runstdby = '0;
    logic [NG-1:0] gen_en;
    logic [NS-1:0] src_en;
    logic [NP-1:0] bus_en;
    logic          main_clk_en;

    int compared = 0;
    int mismatched = 0;
    int exp_mode = 0;
    logic [NG-1:0] e_gen = '0;
    logic [NS-1:0] e_src = '0;
    logic [NP-1:0] e_bus = '0;
    logic          e_main = 1'b0;
    logic [31:0]   rng = 32'h1badc0de;

    always #2.5 clk = ~clk;

    odcr_net uut (
        .clk(clk), .rst_n(rst_n), .pwr_mode(pwr_mode), .periph_req(periph_req),
        .periph_gen_sel(periph_gen_sel), .gen_src_sel(gen_src_sel),
        .gen_runstdby(gen_runstdby), .src_ondemand(src_ondemand),
        .src_runstdby(src_runstdby), .gen_en(gen_en), .src_en(src_en),
        .bus_en(bus_en), .main_clk_en(main_clk_en)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string when);
        check({"R3 R4 R5 gen ", when}, 32'(gen_en), 32'(e_gen));
        check({"R6 R7 R8 R12 src ", when}, 32'(src_en), 32'(e_src));
        check({"R9 bus ", when}, 32'(bus_en), 32'(e_bus));
        check({"R10 main ", when}, 32'(main_clk_en), 32'(e_main));
    endtask

    // Expected values, derived from the requirements
    task automatic predict();
        logic [NG-1:0] dem;
        logic [NS-1:0] sdem;
        bit stby;
        if (pwr_mode != 2'd3) exp_mode = int'(pwr_mode);
        stby = (exp_mode == 2);
        dem = '0;
        for (int p = 0; p < NP; p++)
            if (periph_req[p]) dem[periph_gen_sel[2*p +: 2]] = 1'b1;
        for (int g = 0; g < NG; g++)
            e_gen[g] = stby ? (gen_runstdby[g] & dem[g]) : ((g == 0) ? 1'b1 : dem[g]);
        sdem = '0;
        for (int g = 0; g < NG; g++)
            if (e_gen[g] && gen_src_sel[2*g +: 2] < 2'd3) sdem[gen_src_sel[2*g +: 2]] = 1'b1;
        for (int s = 0; s < NS; s++)
            e_src[s] = (stby && !src_runstdby[s]) ? 1'b0 : (src_ondemand[s] ? sdem[s] : 1'b1);
        e_bus  = (exp_mode == 0) ? '1 : periph_req;
        e_main = stby ? (|periph_req) : 1'b1;
    endtask

    // Inputs are already set at a falling edge
    task automatic step();
        #1;
        check_all("R11 before edge");
        predict();
        @(posedge clk);
        @(negedge clk);
        check_all("after edge");
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        return y ^ (y << 5);
    endfunction

    initial begin
        #(200000 * 5);
        mismatched++;
        $display("FAIL R11 watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset state
        check("R1 gen reset", 32'(gen_en), 32'h0);
        check("R1 src reset", 32'(src_en), 32'h0);
        check("R1 bus reset", 32'(bus_en), 32'h0);
        check("R1 main reset", 32'(main_clk_en), 32'h0);
        rst_n = 1'b1;

        // R12: on-demand source 0 restarts once gen2 (fed by src0) is requested
        pwr_mode = 2'd0; src_ondemand = 3'b001;
        gen_src_sel = {2'd1, 2'd0, 2'd1, 2'd1};   // gen2 -> src0, others -> src1
        periph_gen_sel = '0; periph_gen_sel[7:6] = 2'd2; periph_req = '0;
        step();
        check("R12 src0 stopped", 32'(src_en[0]), 32'h0);
        periph_req = 8'b0000_1000;
        step();
        check("R12 src0 restarted", 32'(src_en[0]), 32'h1);

        // R2: reserved code keeps STANDBY; bus stays gated
        pwr_mode = 2'd2; periph_req = 8'h01; gen_runstdby = '0; src_runstdby = '0;
        step();
        pwr_mode = 2'd3;
        step();
        check("R2 reserved holds standby bus", 32'(bus_en), 32'h01);
        periph_req = '0;
        step();
        check("R2 reserved holds standby main", 32'(main_clk_en), 32'h0);
        // R5: gen0 in standby with run-in-standby set and demand
        pwr_mode = 2'd2; gen_runstdby = 4'b0001; periph_req = 8'h01;
        step();
        check("R5 gen0 standby demand", 32'(gen_en), 32'h1);
        // R6: index 3 selects no source
        pwr_mode = 2'd0; gen_src_sel = 8'hFF; src_ondemand = 3'b111; periph_req = '0;
        step();
        check("R6 unused index", 32'(src_en), 32'h0);

        // Sweep
        for (int it = 0; it < 3000; it++) begin
            rng = nxt(rng);
            pwr_mode = rng[1:0];
            periph_req = rng[9:2] & (rng[10] ? 8'hFF : {4'h0, rng[14:11]});
            gen_runstdby = rng[18:15];
            src_ondemand = rng[21:19];
            src_runstdby = rng[24:22];
            rng = nxt(rng);
            periph_gen_sel = rng[15:0];
            gen_src_sel = rng[23:16];
            step();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule